// File: doc/BRIEF.md
# Paced Phase-Step Frequency Trimmer

This block sets the pace of a train of phase steps sent to the dynamic phase-shift port of a clock synthesizer. The port has three signals: a one-cycle request strobe, an increment/decrement select and a done acknowledge. The synthesizer phase wraps around, so a steady stream of steps in one direction works as a fine frequency offset. Steps in the increment direction make the derived clock faster. Steps in the decrement direction make it slower. There is no end stop, and stepping may go on without limit.

The direction comes from the fill level of an elastic buffer. The fill level is compared against a watermark fixed at the buffer midpoint, with a programmable dead band on each side of it. If the buffer is filling, the block speeds the clock up. If it is draining, the block slows the clock down. Inside the band, no step is issued. A programmable idle gap, counted in phase-shift clock cycles, is added after each acknowledged step. A supervising loop may rewrite the gap once per frame to set the step rate. The block also keeps a signed net-step count and a sticky flag that records a missing acknowledge.

Everything runs on the phase-shift clock. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `phase_step_pacer`

## Requirements
- R1: While `rst_n` is low, `ps_en`, `net_steps` and `ack_timeout` are all zero. The first request can appear no earlier than the third rising edge after `rst_n` rises.
- R2: `ps_en` is high for exactly one cycle per request. A new request is issued only when no request is outstanding, or in the same edge that accepts the acknowledge of the previous one.
- R3: `ps_incdec` changes only together with a new request. It holds its value from the request until the acknowledge, and afterwards.
- R4: With watermark W = 2^(FILL_W-1) and band B = `dead_band`, the direction is set as follows. If fill > W+B, the block requests with `ps_incdec`=1 (speed up). If fill < W-B, it requests with `ps_incdec`=0 (slow down). Otherwise it issues no request.
- R5: With idle gap G, the next request (if demanded) has `ps_en` high exactly G+1 cycles after the cycle in which `ps_done` is high. With G=0 and a 12-cycle acknowledge, requests repeat every 13 cycles.
- R6: The gap used is the value of `idle_gap` in the cycle the acknowledge arrives. Changing `idle_gap` during a running gap does not change that gap.
- R7: `net_steps` is a signed two's-complement count. It goes up by 1 for each acknowledged increment and down by 1 for each acknowledged decrement, and the new value is visible in the cycle after `ps_done`.
- R8: If `ps_done` does not arrive within TMO_CYC cycles of a request, `ack_timeout` is set and stays set until reset. The request is dropped, `net_steps` is unchanged, and a new gap starts.
- R9: A `ps_done` pulse that arrives while no request is outstanding is ignored. `net_steps` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_level | input | FILL_W | Current buffer occupancy |
| dead_band | input | FILL_W | Half-width of the no-step band around the watermark |
| idle_gap | input | GAP_W | Idle cycles inserted after each acknowledged step |
| ps_done | input | 1 | Phase-step acknowledge from the synthesizer |
| ps_en | output | 1 | One-cycle phase-step request |
| ps_incdec | output | 1 | Step direction: 1 = increment (faster), 0 = decrement (slower) |
| net_steps | output | NET_W | Signed net count of acknowledged steps |
| ack_timeout | output | 1 | Sticky flag: an acknowledge failed to arrive |

## Verification
Every output is registered, so each result follows the stimulus that causes it by a fixed number of edges:
- A request comes one edge after the gap expires with demand present, which is G+1 cycles after the acknowledge cycle.
- The net count moves one edge after `ps_done`.
- The timeout flag rises TMO_CYC cycles after an unanswered request.

A behavioural reference in the bench advances on each rising edge using the inputs held since the previous falling edge. Its request, direction, count and flag are compared with the outputs at every falling edge, so each result is checked in the exact cycle it is due. Directed checks then measure request spacing across gap changes, silence inside the dead band, and the count and flag around dropped and stray acknowledges.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic {
    ST_GAP  = 1'b0,
    ST_WAIT = 1'b1
  } hs_state_t;
endpackage

// File: rtl/pacer_dir.sv
module pacer_dir #(
  parameter int FILL_W    = 8,
  parameter int WATERMARK = 128
) (
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] band,
  output logic              want_step,
  output logic              want_up
);
  localparam int CW = FILL_W + 1;
  localparam logic [CW-1:0] WM = CW'(WATERMARK);

  logic [CW-1:0] fill_x, band_x, upper, fill_plus;
  logic          above, below;

  always_comb begin
    fill_x    = {1'b0, fill};
    band_x    = {1'b0, band};
    upper     = WM + band_x;
    fill_plus = fill_x + band_x;
    above     = fill_x > upper;
    below     = fill_plus < WM;
    want_up   = above;
    want_step = above | below;
  end
endmodule

// File: rtl/pacer_gap_timer.sv
module pacer_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && cnt_q > GAP_W'(1)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q <= GAP_W'(1));

  a_r6_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/pacer_handshake.sv
module pacer_handshake
  import pacer_pkg::*;
#(
  parameter int TMO_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_step,
  input  logic want_up,
  input  logic gap_expired,
  input  logic gap_cfg_zero,
  input  logic ps_done,
  output logic ps_en,
  output logic ps_incdec,
  output logic waiting,
  output logic gap_load,
  output logic ack_valid,
  output logic ack_up,
  output logic timeout
);
  localparam int WC_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(TMO_CYC - 1);

  hs_state_t       st_q, st_d;
  logic [WC_W-1:0] wc_q, wc_d;
  logic            en_q, en_d, dir_q, dir_d, tmo_q, tmo_d;

  always_comb begin
    st_d     = st_q;
    wc_d     = wc_q;
    en_d     = 1'b0;
    dir_d    = dir_q;
    tmo_d    = tmo_q;
    gap_load = 1'b0;
    unique case (st_q)
      ST_GAP: begin
        if (gap_expired && want_step) begin
          en_d  = 1'b1;
          dir_d = want_up;
          wc_d  = '0;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ps_done) begin
          if (gap_cfg_zero && want_step) begin
            en_d  = 1'b1;
            dir_d = want_up;
            wc_d  = '0;
          end else begin
            st_d     = ST_GAP;
            gap_load = 1'b1;
          end
        end else if (wc_q == WC_LAST) begin
          tmo_d    = 1'b1;
          st_d     = ST_GAP;
          gap_load = 1'b1;
        end else begin
          wc_d = wc_q + WC_W'(1);
        end
      end
      default: st_d = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_GAP;
      wc_q  <= '0;
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wc_q  <= wc_d;
      en_q  <= en_d;
      dir_q <= dir_d;
      tmo_q <= tmo_d;
    end
  end

  assign ps_en     = en_q;
  assign ps_incdec = dir_q;
  assign waiting   = (st_q == ST_WAIT);
  assign ack_valid = waiting && ps_done;
  assign ack_up    = dir_q;
  assign timeout   = tmo_q;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |-> (!$past(waiting) || $past(ps_done)));
  a_r3_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !ps_done) |=> $stable(ps_incdec));
  a_r8_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);
endmodule

// File: rtl/pacer_step_count.sv
module pacer_step_count #(
  parameter int NET_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ack_valid,
  input  logic                    ack_up,
  output logic signed [NET_W-1:0] net
);
  logic signed [NET_W-1:0] net_q, net_d;

  always_comb begin
    net_d = ack_up ? net_q + NET_W'(1) : net_q - NET_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         net_q <= '0;
    else if (ack_valid) net_q <= net_d;
  end

  assign net = net_q;

  a_r7_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (net_q == $past(net_q) + NET_W'(1) || net_q == $past(net_q) - NET_W'(1)));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> $stable(net_q));
endmodule

// File: rtl/phase_step_pacer.sv
module phase_step_pacer #(
  parameter int FILL_W  = 8,
  parameter int GAP_W   = 8,
  parameter int NET_W   = 16,
  parameter int TMO_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] fill_level,
  input  logic [FILL_W-1:0] dead_band,
  input  logic [GAP_W-1:0]  idle_gap,
  input  logic              ps_done,
  output logic              ps_en,
  output logic              ps_incdec,
  output logic [NET_W-1:0]  net_steps,
  output logic              ack_timeout
);
  localparam int WATERMARK = 1 << (FILL_W - 1);

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic want_step, want_up, gap_expired, waiting, gap_load, ack_valid, ack_up;
  logic signed [NET_W-1:0] net;

  pacer_dir #(.FILL_W(FILL_W), .WATERMARK(WATERMARK)) u_dir (
    .fill(fill_level), .band(dead_band),
    .want_step(want_step), .want_up(want_up)
  );

  pacer_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_s2), .run(!waiting), .load(gap_load),
    .load_val(idle_gap), .expired(gap_expired)
  );

  pacer_handshake #(.TMO_CYC(TMO_CYC)) u_hs (
    .clk(clk), .rst_n(rst_s2), .want_step(want_step), .want_up(want_up),
    .gap_expired(gap_expired), .gap_cfg_zero(idle_gap == '0),
    .ps_done(ps_done), .ps_en(ps_en), .ps_incdec(ps_incdec),
    .waiting(waiting), .gap_load(gap_load), .ack_valid(ack_valid),
    .ack_up(ack_up), .timeout(ack_timeout)
  );

  pacer_step_count #(.NET_W(NET_W)) u_cnt (
    .clk(clk), .rst_n(rst_s2), .ack_valid(ack_valid), .ack_up(ack_up),
    .net(net)
  );

  assign net_steps = net;

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_s2 |=> !ps_en);
endmodule

// File: tb/sim_phase_step_pacer.sv
module sim_phase_step_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int FILL_W  = 8;
  localparam int GAP_W   = 8;
  localparam int NET_W   = 16;
  localparam int TMO_CYC = 32;
  localparam int ACK_LAT = 12;
  localparam int WM      = 1 << (FILL_W - 1);
  localparam int WDOG    = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FILL_W-1:0] fill_level = '0;
  logic [FILL_W-1:0] dead_band = '0;
  logic [GAP_W-1:0]  idle_gap = '0;
  logic resp_done = 1'b0;
  logic spur = 1'b0;
  logic ack_on = 1'b1;
  logic ps_done;
  logic ps_en, ps_incdec, ack_timeout;
  logic [NET_W-1:0] net_steps;

  assign ps_done = resp_done | spur;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_step_pacer #(.FILL_W(FILL_W), .GAP_W(GAP_W), .NET_W(NET_W), .TMO_CYC(TMO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_level(fill_level), .dead_band(dead_band),
    .idle_gap(idle_gap), .ps_done(ps_done), .ps_en(ps_en), .ps_incdec(ps_incdec),
    .net_steps(net_steps), .ack_timeout(ack_timeout)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  int rel = 0;
  bit m_wait = 0, m_en = 0, m_dir = 0, m_tmo = 0;
  int m_cnt = 0, m_wc = 0;
  logic signed [NET_W-1:0] m_net = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rel = 0; m_wait = 0; m_en = 0; m_dir = 0; m_tmo = 0;
      m_cnt = 0; m_wc = 0; m_net = '0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      bit up, dn, dem, nen;
      up  = int'(fill_level) > WM + int'(dead_band);
      dn  = int'(fill_level) + int'(dead_band) < WM;
      dem = up || dn;
      nen = 0;
      if (m_wait) begin
        if (ps_done) begin
          m_net = m_dir ? m_net + 1 : m_net - 1;
          if (idle_gap == 0 && dem) begin
            nen = 1; m_dir = up; m_wc = 0;
          end else begin
            m_wait = 0; m_cnt = int'(idle_gap);
          end
        end else if (m_wc == TMO_CYC - 1) begin
          m_tmo = 1; m_wait = 0; m_cnt = int'(idle_gap);
        end else begin
          m_wc++;
        end
      end else if (m_cnt > 1) begin
        m_cnt--;
      end else if (dem) begin
        nen = 1; m_dir = up; m_wait = 1; m_wc = 0;
      end
      m_en = nen;
    end
  end

  // synthesizer responder and request spacing monitor
  int cd = 0;
  int last_en = -1;
  int period = 0;
  int n_en = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cd = 0; resp_done = 1'b0;
    end else begin
      resp_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) resp_done = 1'b1;
      end
      if (ps_en && ack_on) cd = ACK_LAT;
      if (ps_en) begin
        if (last_en >= 0) period = cyc - last_en;
        last_en = cyc;
        n_en++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 ps_en", ps_en, m_en);
      check("R3/R4 ps_incdec", ps_incdec, m_dir);
      check("R7 net_steps", $signed(net_steps), m_net);
      check("R8 ack_timeout", ack_timeout, m_tmo);
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_en();
    int e;
    e = n_en;
    while (n_en == e) step(1);
  endtask

  initial begin
    int e;
    logic [NET_W-1:0] snap;
    fill_level = 8'd128; dead_band = 8'd2; idle_gap = '0;
    step(3);
    check("R1 ps_en in reset", ps_en, 0);
    check("R1 net in reset", net_steps, 0);
    check("R1 timeout in reset", ack_timeout, 0);
    rst_n = 1'b1;
    fill_level = 8'd200;
    step(1);
    check("R1 no request right after release", ps_en, 0);

    step(80);
    check("R5 period gap0", period, 13);
    check("R4 up direction", ps_incdec, 1);

    idle_gap = 8'd5;
    step(80);
    check("R5 period gap5", period, 18);

    while (!resp_done) step(1);
    step(2);
    idle_gap = 8'd40;
    wait_en();
    check("R6 running gap unchanged", period, 18);
    wait_en();
    check("R6 new gap applied", period, 53);

    idle_gap = '0;
    fill_level = 8'd20;
    step(40);
    snap = net_steps;
    step(200);
    check("R4 down direction", ps_incdec, 0);
    check("R7 net decreased", ($signed(net_steps) < $signed(snap)), 1);

    fill_level = 8'd130;
    step(30);
    e = n_en;
    step(100);
    check("R4 no step inside band", n_en, e);

    snap = net_steps;
    spur = 1'b1;
    step(1);
    spur = 1'b0;
    step(3);
    check("R9 stray done ignored", net_steps, snap);

    fill_level = 8'd131;
    e = n_en;
    step(20);
    check("R4 step just above band", (n_en > e), 1);

    ack_on = 1'b0;
    step(80);
    check("R8 timeout set", ack_timeout, 1);
    snap = net_steps;
    step(40);
    check("R8 net unchanged without ack", net_steps, snap);
    ack_on = 1'b1;
    step(60);
    check("R8 timeout sticky", ack_timeout, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule